// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive. After reset it holds off all activity for a start-up pause derived from the clock frequency. It then runs a fixed number of RAS-only wake-up cycles on its own, without asking for the bus. Only then does it raise `ready`, and from that point host requests are passed through to the access sequencer.

Once ready, an interval timer earns one refresh credit per row period. The period is the retention window divided by the number of rows. Credits are stored in a saturating pending counter. While credits are outstanding the block raises `ref_req`. Each time the sequencer answers with `ref_gnt`, the block drives the strobes for as many refresh cycles as it holds credits, back to back.

A mode input picks the refresh style for each burst. In CAS-before-RAS style no address is needed, and CAS stays low across chained cycles. In RAS-only style CAS stays high and the address comes from an internal row counter that wraps.

Top module: `dram_ref_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n` and `cas_n` are 1, `addr` is 0, and `ready`, `ref_req` and `bus_own` are 0.
- R2: No RAS strobe appears before PAUSE_CYC = CLK_KHZ*PAUSE_US/1000 clock cycles have passed since reset release.
- R3: After the pause, exactly INIT_CYCLES RAS-only cycles are run with `cas_n`=1 and `addr`=0, without any handshake. `ready` rises after they finish.
- R4: `ready` stays 0 until initialization ends and never falls afterwards. `host_ok` = `host_req` AND `ready`. `ref_req` is 0 while `ready` is 0.
- R5: Once ready, one refresh credit is earned every INTERVAL = CLK_KHZ*RETENTION_US/1000/2^ROW_W cycles. The first credit arrives INTERVAL cycles after `ready` rises. With `ref_gnt` held high, each credit produces exactly one refresh cycle.
- R6: When `refresh_mode`=0 (CAS-before-RAS), `cas_n` is already low in the cycle before `ras_n` falls. `addr` is 0 whenever `cas_n` is low.
- R7: When `refresh_mode`=1 (RAS-only), `cas_n` stays 1 for the whole cycle. `addr` shows the row counter, which starts at 0 after reset, increments after each RAS-only refresh, and wraps from 2^ROW_W-1 to 0.
- R8: Credits earned while `ref_gnt` is low are kept. `ref_req` is 1 while credits remain or a cycle is running. Once granted, all held credits are spent in consecutive cycles, with RAS falls exactly T_RAS+T_RP cycles apart. `ref_req` then drops to 0.
- R9: The pending count saturates at PEND_MAX. A longer wait without a grant yields exactly PEND_MAX refreshes.
- R10: Between consecutive CAS-before-RAS cycles of one burst, `cas_n` stays low while only `ras_n` is cycled.
- R11: A refresh cycle starts only after `ref_gnt` has been seen high. `bus_own` is 1 exactly while a cycle is in progress. Outside it the strobes are inactive and `addr` is 0.
- R12: Each RAS low pulse lasts exactly T_RAS cycles. RAS stays high at least T_RP cycles between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_mode | input | 1 | 0 = CAS-before-RAS, 1 = RAS-only; sampled at burst start |
| ref_gnt | input | 1 | Strobe grant from the access sequencer |
| host_req | input | 1 | Host access request |
| ref_req | output | 1 | Refresh wants the strobes |
| host_ok | output | 1 | Host request passed on after init |
| ready | output | 1 | Initialization finished |
| bus_own | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | ROW_W | Row address for RAS-only cycles |

## Verification
The bound checker watches, on every cycle, these rules:
- The gating of `host_ok` and `ref_req` by `ready`, and that `ready` never drops.
- Quiet strobes whenever the bus is not owned, and that ownership begins only after a grant.
- The exact RAS pulse width.
- CAS leading RAS in CAS-before-RAS cycles, and a zero address while CAS is low.

Only the bench scenarios can show the quantities that depend on history:
- The pause length and the count of wake-up cycles.
- The credit rate per interval and the burst size after a withheld grant, including saturation.
- The chaining of CAS-low cycles.
- The row sequence through its wrap.

// File: rtl/dram_ref_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_ref_pkg;

    // Strobe engine phases
    typedef enum logic [1:0] {
        ST_IDLE,   // bus released
        ST_LEAD,   // CAS low ahead of RAS (CAS-before-RAS only)
        ST_ACT,    // RAS low
        ST_PRE     // RAS precharge
    } ref_state_t;

    // Kind of cycle the engine is running
    typedef enum logic [1:0] {
        CK_INIT,   // power-up wake-up cycle
        CK_CBR,    // CAS-before-RAS refresh
        CK_ROW     // RAS-only refresh with row counter
    } ref_kind_t;

    // Counter width able to hold values 0..n-1
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ref_powerup_ctl.sv
`timescale 1ns/1ps
// Power-up sequencing: waits PAUSE_CYC cycles after reset release, then
// lets the engine run INIT_CYCLES wake-up cycles, then raises ready.
// Assumes: init_done pulses once per finished wake-up RAS pulse, and
// eng_idle is high whenever the strobe engine has released the bus.
module ref_powerup_ctl
    import dram_ref_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 20000,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    input  logic eng_idle,
    output logic pause_done,
    output logic init_nz,
    output logic init_many,
    output logic ready
);
    localparam int unsigned PW = cnt_w(PAUSE_CYC + 1);
    localparam int unsigned NW = cnt_w(INIT_CYCLES + 1);

    logic [PW-1:0] pause_cnt;
    logic [NW-1:0] init_left;

    // Start-up pause counter, stops once the pause has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cnt  <= '0;
            pause_done <= (PAUSE_CYC == 0);
        end else if (!pause_done) begin
            pause_cnt  <= pause_cnt + 1'b1;
            pause_done <= (pause_cnt == PW'(PAUSE_CYC - 1));
        end
    end

    // Remaining wake-up cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_left <= NW'(INIT_CYCLES);
        else if (init_done && init_left != '0)
            init_left <= init_left - 1'b1;
    end

    // Ready latches once pause and wake-up cycles are both finished
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready <= 1'b0;
        else if (pause_done && init_left == '0 && eng_idle)
            ready <= 1'b1;
    end

    assign init_nz   = (init_left != '0);
    assign init_many = (init_left > NW'(1));

endmodule

// File: rtl/ref_interval_timer.sv
`timescale 1ns/1ps
// Refresh interval timer and pending-credit counter.
// A tick every INTERVAL cycles while run is high adds one credit,
// saturating at PEND_MAX; consume removes one when a refresh pulse ends.
// Assumes: consume is only raised while at least one credit is held.
module ref_interval_timer
    import dram_ref_pkg::*;
#(
    parameter int unsigned INTERVAL = 1562,
    parameter int unsigned PEND_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic consume,
    output logic tick,
    output logic pend_nz,
    output logic pend_many
);
    localparam int unsigned IW = cnt_w(INTERVAL);
    localparam int unsigned QW = cnt_w(PEND_MAX + 1);

    logic [IW-1:0] icnt;
    logic [QW-1:0] pend;

    assign tick = run && (icnt == IW'(INTERVAL - 1));

    // Free-running interval counter, active once the DRAM is ready
    always_ff @(posedge clk) begin
        if (!rst_n)
            icnt <= '0;
        else if (run)
            icnt <= tick ? '0 : icnt + 1'b1;
    end

    // Pending credits: add on tick, remove on consume, saturate on top
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (tick && !consume && pend != QW'(PEND_MAX))
            pend <= pend + 1'b1;
        else if (consume && !tick && pend != '0)
            pend <= pend - 1'b1;
    end

    assign pend_nz   = (pend != '0);
    assign pend_many = (pend > QW'(1));

endmodule

// File: rtl/ref_cycle_engine.sv
`timescale 1ns/1ps
// Strobe engine: runs wake-up, CAS-before-RAS and RAS-only cycles.
// Phases: optional CAS lead (T_CSR), RAS low (T_RAS), precharge (T_RP).
// Consecutive cycles of one burst skip the idle phase; CAS-before-RAS
// bursts keep CAS low through precharge. Mode is captured per burst.
// Assumes: gnt is only consulted when a cycle is about to start.
module ref_cycle_engine
    import dram_ref_pkg::*;
#(
    parameter int unsigned ROW_W = 9,
    parameter int unsigned T_CSR = 2,
    parameter int unsigned T_RAS = 3,
    parameter int unsigned T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pause_done,
    input  logic             init_nz,
    input  logic             init_many,
    input  logic             ready,
    input  logic             gnt,
    input  logic             mode_row,
    input  logic             pend_nz,
    input  logic             pend_many,
    input  logic             tick,
    output logic             init_done,
    output logic             consume,
    output logic             busy,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] addr
);
    localparam int unsigned TMAX0 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int unsigned TMAX  = (TMAX0 > T_RP) ? TMAX0 : T_RP;
    localparam int unsigned TW    = cnt_w(TMAX);

    ref_state_t       state;
    ref_kind_t        kind;
    logic [TW-1:0]    tcnt;
    logic             cont;
    logic [ROW_W-1:0] row;

    logic lead_end, act_end, pre_end;

    assign lead_end = (state == ST_LEAD) && (tcnt == TW'(T_CSR - 1));
    assign act_end  = (state == ST_ACT)  && (tcnt == TW'(T_RAS - 1));
    assign pre_end  = (state == ST_PRE)  && (tcnt == TW'(T_RP - 1));

    // Phase sequencing and burst continuation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kind  <= CK_INIT;
            tcnt  <= '0;
            cont  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    if (!ready && pause_done && init_nz) begin
                        kind  <= CK_INIT;
                        state <= ST_ACT;
                    end else if (ready && gnt && pend_nz) begin
                        kind  <= mode_row ? CK_ROW : CK_CBR;
                        state <= mode_row ? ST_ACT : ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    tcnt <= lead_end ? '0 : tcnt + 1'b1;
                    if (lead_end) state <= ST_ACT;
                end
                ST_ACT: begin
                    tcnt <= act_end ? '0 : tcnt + 1'b1;
                    if (act_end) begin
                        state <= ST_PRE;
                        cont  <= (kind == CK_INIT) ? init_many
                                                   : (gnt && (pend_many || tick));
                    end
                end
                default: begin
                    tcnt <= pre_end ? '0 : tcnt + 1'b1;
                    if (pre_end) state <= cont ? ST_ACT : ST_IDLE;
                end
            endcase
        end
    end

    // Row counter for RAS-only refresh, advances after each such pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (act_end && kind == CK_ROW)
            row <= row + 1'b1;
    end

    assign init_done = act_end && (kind == CK_INIT);
    assign consume   = act_end && (kind != CK_INIT);
    assign busy      = (state != ST_IDLE);
    assign ras_n     = (state != ST_ACT);
    assign cas_n     = !((kind == CK_CBR) &&
                         (state == ST_LEAD || state == ST_ACT ||
                          (state == ST_PRE && cont)));
    assign addr      = (kind == CK_ROW && state == ST_ACT) ? row : '0;

endmodule

// File: rtl/dram_ref_sched.sv
`timescale 1ns/1ps
// DRAM refresh and power-up scheduler top.
// Derives pause and refresh interval from the clock frequency, gates host
// requests until initialization ends, and requests the strobes from the
// access sequencer whenever refresh credits are outstanding.
// Assumes: the sequencer keeps ref_gnt high until ref_req drops.
module dram_ref_sched
    import dram_ref_pkg::*;
#(
    parameter int unsigned CLK_KHZ      = 100000,
    parameter int unsigned RETENTION_US = 8000,
    parameter int unsigned PAUSE_US     = 200,
    parameter int unsigned ROW_W        = 9,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned PEND_MAX     = 7,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned T_RAS        = 3,
    parameter int unsigned T_RP         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_mode,
    input  logic             ref_gnt,
    input  logic             host_req,
    output logic             ref_req,
    output logic             host_ok,
    output logic             ready,
    output logic             bus_own,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] addr
);
    localparam int unsigned PAUSE_CYC = CLK_KHZ * PAUSE_US / 1000;
    localparam int unsigned INTERVAL  = CLK_KHZ * RETENTION_US / 1000 / (1 << ROW_W);

    logic pause_done, init_nz, init_many, init_done;
    logic tick, pend_nz, pend_many, consume;

    ref_powerup_ctl #(
        .PAUSE_CYC  (PAUSE_CYC),
        .INIT_CYCLES(INIT_CYCLES)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .eng_idle  (!bus_own),
        .pause_done(pause_done),
        .init_nz   (init_nz),
        .init_many (init_many),
        .ready     (ready)
    );

    ref_interval_timer #(
        .INTERVAL(INTERVAL),
        .PEND_MAX(PEND_MAX)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ready),
        .consume  (consume),
        .tick     (tick),
        .pend_nz  (pend_nz),
        .pend_many(pend_many)
    );

    ref_cycle_engine #(
        .ROW_W(ROW_W),
        .T_CSR(T_CSR),
        .T_RAS(T_RAS),
        .T_RP (T_RP)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .pause_done(pause_done),
        .init_nz   (init_nz),
        .init_many (init_many),
        .ready     (ready),
        .gnt       (ref_gnt),
        .mode_row  (refresh_mode),
        .pend_nz   (pend_nz),
        .pend_many (pend_many),
        .tick      (tick),
        .init_done (init_done),
        .consume   (consume),
        .busy      (bus_own),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .addr      (addr)
    );

    assign host_ok = host_req && ready;
    assign ref_req = ready && (pend_nz || bus_own);

endmodule

// File: rtl/dram_ref_sched_chk.sv
`timescale 1ns/1ps
// Cycle-level checker for dram_ref_sched, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module dram_ref_sched_chk #(
    parameter int unsigned ROW_W = 9,
    parameter int unsigned T_RAS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_gnt,
    input logic             host_req,
    input logic             ref_req,
    input logic             host_ok,
    input logic             ready,
    input logic             bus_own,
    input logic             ras_n,
    input logic             cas_n,
    input logic [ROW_W-1:0] addr
);
    logic [15:0] low_cnt;

    // Count sampled cycles with RAS low
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!ras_n)
            low_cnt <= low_cnt + 1'b1;
        else
            low_cnt <= '0;
    end

    // R4
    not_ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!host_ok && !ref_req));

    // R4
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R11
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (ras_n && cas_n && addr == '0));

    // R11
    start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_own) && ready) |-> $past(ref_gnt));

    // R12
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt == 16'(T_RAS)));

    // R6
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R6
    cas_low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (addr == '0));

    // R3
    init_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !ready) |-> cas_n);

endmodule

bind dram_ref_sched dram_ref_sched_chk #(
    .ROW_W(ROW_W),
    .T_RAS(T_RAS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_gnt (ref_gnt),
    .host_req(host_req),
    .ref_req (ref_req),
    .host_ok (host_ok),
    .ready   (ready),
    .bus_own (bus_own),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .addr    (addr)
);

// File: tb/dram_ref_sched_test.sv
`timescale 1ns/1ps
// Bench for dram_ref_sched: directed and seeded random grant-withhold
// scenarios, with a negedge monitor that checks every strobe event.
module dram_ref_sched_test;
    localparam int CLK_KHZ = 4000;
    localparam int RET_US  = 8000;
    localparam int PAUSE_US = 200;
    localparam int ROW_W   = 9;
    localparam int INITN   = 8;
    localparam int PMAX    = 7;
    localparam int TCSR    = 2;
    localparam int TRAS    = 3;
    localparam int TRP     = 2;
    localparam int PAUSE   = CLK_KHZ * PAUSE_US / 1000;
    localparam int IVL     = CLK_KHZ * RET_US / 1000 / (1 << ROW_W);
    localparam int NROWS   = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_mode = 1'b0;
    logic ref_gnt = 1'b0;
    logic host_req = 1'b0;
    logic ref_req, host_ok, ready, bus_own, ras_n, cas_n;
    logic [ROW_W-1:0] addr;

    dram_ref_sched #(
        .CLK_KHZ(CLK_KHZ), .RETENTION_US(RET_US), .PAUSE_US(PAUSE_US),
        .ROW_W(ROW_W), .INIT_CYCLES(INITN), .PEND_MAX(PMAX),
        .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .refresh_mode(refresh_mode),
        .ref_gnt(ref_gnt), .host_req(host_req), .ref_req(ref_req),
        .host_ok(host_ok), .ready(ready), .bus_own(bus_own),
        .ras_n(ras_n), .cas_n(cas_n), .addr(addr)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Monitor state
    int  r = 0;
    bit  ready_seen = 0;
    int  first_fall = -1;
    int  last_fall = -1;
    int  init_falls = 0;
    int  fall_total = 0;
    int  lo_len = 0;
    int  hi_len = 0;
    bit  ras_prev = 1;
    bit  cas_prev = 1;
    bit  cas_high_seen = 1;
    bit  last_cbr = 0;
    int  cbr_chain_seen = 0;
    int  exp_row = 0;
    bit  saw_511 = 0;
    bit  saw_wrap = 0;
    bit  sc_on = 0;
    int  sc_falls = 0;
    int  sc_gap_bad = 0;

    function automatic int next_tick(input int c);
        int first;
        first = r + IVL - 1;
        if (c <= first) return first;
        return first + ((c - first + IVL - 1) / IVL) * IVL;
    endfunction

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(host_ok == (host_req && ready), "R4 host_ok", host_ok, host_req && ready);
            if (!ready) chk(ref_req == 1'b0, "R4 ref_req before ready", ref_req, 0);
            if (ready_seen && !ready) chk(0, "R4 ready dropped", 0, 1);
            if (ready && !ready_seen) begin
                ready_seen = 1;
                r = cyc;
                chk(init_falls == INITN, "R3 wake-up count", init_falls, INITN);
            end
            if (ready && refresh_mode && bus_own)
                chk(cas_n == 1'b1, "R7 cas during RAS-only", cas_n, 1);
            if (ras_n) begin
                if (!ras_prev) chk(lo_len == TRAS, "R12 RAS low width", lo_len, TRAS);
                lo_len = 0;
                hi_len++;
            end else begin
                if (ras_prev) begin
                    int gap;
                    gap = cyc - last_fall;
                    if (first_fall < 0) first_fall = cyc;
                    if (last_fall >= 0) chk(hi_len >= TRP, "R12 precharge", hi_len, TRP);
                    if (!ready) begin
                        init_falls++;
                        chk(cas_n == 1'b1 && addr == '0, "R3 wake-up strobe", {cas_n, addr}, 1 << ROW_W);
                        last_cbr = 0;
                    end else if (!refresh_mode) begin
                        chk(!cas_n && !cas_prev, "R6 CAS leads RAS", {cas_prev, cas_n}, 0);
                        chk(addr == '0, "R6 address zero", addr, 0);
                        if (last_cbr && last_fall >= 0 && gap == TRAS + TRP) begin
                            chk(!cas_high_seen, "R10 CAS held low in chain", cas_high_seen, 0);
                            cbr_chain_seen++;
                        end
                        last_cbr = 1;
                    end else begin
                        chk(cas_n == 1'b1, "R7 CAS high", cas_n, 1);
                        chk(int'(addr) == exp_row, "R7 row address", addr, exp_row);
                        if (saw_511 && addr == '0) saw_wrap = 1;
                        saw_511 = (int'(addr) == NROWS - 1);
                        exp_row = (exp_row + 1) % NROWS;
                        last_cbr = 0;
                    end
                    if (sc_on) begin
                        if (sc_falls > 0 && gap != TRAS + TRP) sc_gap_bad++;
                        sc_falls++;
                    end
                    fall_total++;
                    last_fall = cyc;
                    cas_high_seen = 0;
                end
                hi_len = 0;
                lo_len++;
            end
            if (cas_n) cas_high_seen = 1;
            ras_prev = ras_n;
            cas_prev = cas_n;
        end
    end

    // Random host request traffic, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            host_req = 1'($urandom_range(0, 1));
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        report();
    end

    // Withhold grant over k ticks, then grant and count the burst
    task automatic run_scn(input int k, input bit m);
        int t0, g, base, expn;
        t0 = next_tick(cyc + 6);
        wait_to(t0 - 5);
        refresh_mode = m;
        ref_gnt = 1'b0;
        base = fall_total;
        g = t0 + (k - 1) * IVL + 3;
        wait_to(g);
        chk(fall_total == base, "R11 no strobe without grant", fall_total - base, 0);
        chk(ref_req == 1'b1, "R8 request while credits held", ref_req, 1);
        sc_falls = 0;
        sc_gap_bad = 0;
        sc_on = 1;
        ref_gnt = 1'b1;
        wait_to(t0 + k * IVL - 2);
        sc_on = 0;
        chk(ref_req == 1'b0, "R8 request drops after burst", ref_req, 0);
        expn = (k > PMAX) ? PMAX : k;
        if (k > PMAX) chk(sc_falls == expn, "R9 saturated burst", sc_falls, expn);
        else          chk(sc_falls == expn, "R8 burst size", sc_falls, expn);
        chk(sc_gap_bad == 0, "R8 back-to-back spacing", sc_gap_bad, 0);
    endtask

    initial begin
        int t0, base;
        void'($urandom(32'h5eed_0417));
        repeat (4) begin
            @(negedge clk);
            chk(ras_n && cas_n && addr == '0, "R1 reset strobes", {ras_n, cas_n}, 3);
            chk(!ready && !ref_req && !bus_own, "R1 reset flags", {ready, ref_req, bus_own}, 0);
        end
        base = cyc;
        rst_n = 1'b1;
        while (!ready_seen) @(negedge clk);
        chk(first_fall >= base + PAUSE + 1, "R2 start-up pause", first_fall, base + PAUSE + 1);
        ref_gnt = 1'b1;

        // R5: free-running rate, one refresh per interval
        t0 = next_tick(cyc + 6);
        wait_to(t0 - 5);
        base = fall_total;
        wait_to(t0 + 3 * IVL + 20);
        chk(fall_total - base == 4, "R5 refresh rate", fall_total - base, 4);

        // Directed corners
        run_scn(3, 1'b0);
        run_scn(12, 1'b1);
        run_scn(9, 1'b0);
        run_scn(1, 1'b1);
        run_scn(PMAX, 1'b0);

        // Seeded random grant withholding
        for (int i = 0; i < 18; i++)
            run_scn(int'($urandom_range(1, 10)), 1'($urandom_range(0, 1)));

        chk(cbr_chain_seen > 0, "R10 chained CAS-before-RAS seen", cbr_chain_seen, 1);

        // R7: run RAS-only long enough to wrap the row counter
        t0 = next_tick(cyc + 6);
        wait_to(t0 - 5);
        refresh_mode = 1'b1;
        wait_to(t0 + (NROWS + 4) * IVL);
        chk(saw_wrap, "R7 row counter wrap", saw_wrap, 1);

        report();
    end

endmodule